// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes a bank of interrupt input lines to message-signalled deliveries. Every pin has a 64-bit routing entry that holds a vector, a delivery mode, a destination and destination mode, a polarity flag, a trigger type and a mask. A pending bit per pin records requests that have not yet been delivered. Each delivery leaves the block as one address/data message on a valid/ready interface.

Pins programmed as edge type latch a rising edge only while unmasked, and their pending bit clears once they are delivered. Pins programmed as level type follow their input. After a level pin is delivered, its remote-IRR flag blocks it until an end-of-interrupt carrying the same vector clears the flag. Entries whose delivery mode is the external-controller mode take their vector from an acknowledge handshake instead of from the entry. Legacy input 0 is folded onto pin 2.

A front end programs the entries through a 32-bit half-entry write/read port. Any eligible pin is picked up without a separate trigger, so a write that unmasks a pending pin also starts its delivery.

Top module: `irc_router`

## Requirements
- R1: After reset every entry reads back with only the mask bit (bit 16) set: lower half 0x0001_0000 and upper half 0. No message is valid and no acknowledge is raised.
- R2: An unmasked edge-type pin (bit 15 = 0) that sees a rising input produces exactly one message. Its pending state is then gone, so no further message follows.
- R3: A rising edge on an edge-type pin while its mask bit is set is discarded. Unmasking the pin afterwards produces no message.
- R4: A high input on an unmasked level-type pin (bit 15 = 1) with remote-IRR (bit 14) clear produces one message and sets remote-IRR. While remote-IRR stays set, that pin produces no further messages.
- R5: A level-type pin whose input has dropped is no longer pending. An end-of-interrupt that then clears its remote-IRR produces no message.
- R6: An end-of-interrupt clears remote-IRR on every entry whose remote-IRR is set and whose vector (bits 7:0) equals the carried vector. If such an entry is unmasked and its input is still high, it is delivered again. An end-of-interrupt with a different vector changes nothing.
- R7: An entry whose mask bit is set never produces a message, even when its pin is pending. A write that clears the mask of a pending level pin leads to its delivery.
- R8: When the delivery mode (bits 10:8) is 3'b111, the message vector is taken from `inta_vector`, and `inta_ack` pulses for one cycle in the cycle the message is loaded. Any other mode uses the entry vector.
- R9: Legacy input 0 drives pin 2, together with input 2. Pin 0 has no source. Every other input drives the pin with its own index.
- R10: The message address is MSG_BASE (0xFEE0_0000) OR destination mode (bit 11) << 2 OR destination (bits 63:56) << 12. The message data is vector OR delivery mode << 8 OR polarity (bit 13) << 14 OR trigger type << 15.
- R11: Pending pins are delivered in ascending pin order, at most one message per cycle, back to back while `msg_ready` is high. A message held while `msg_ready` is low keeps its address, data and pin stable.
- R12: Remote-IRR cannot be changed through the write port. Writes to bit 14 of the lower half are ignored.
- R13: A rising edge that arrives in the same cycle its edge pin is delivered is kept pending, so a second message follows.
- R14: Writes to a pin index at or above NUM_PINS are ignored, and reads of such an index return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_PINS | Interrupt input lines (index 0 is the legacy line folded onto pin 2) |
| cfg_we | input | 1 | Write strobe for the routing table |
| cfg_idx | input | IW | Pin index of the accessed entry |
| cfg_hi | input | 1 | Selects the upper (1) or lower (0) 32 bits of the entry |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected half entry, remote-IRR merged in at bit 14 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| inta_vector | input | 8 | Vector supplied by the external controller |
| inta_ack | output | 1 | Acknowledge pulse when an external-mode entry is delivered |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| msg_pin | output | IW | Pin that produced the message |

## Verification
Two things can land on one edge-type pin in the same clock: the clearing of its pending bit because it is being delivered, and the setting of that bit by a fresh rising edge. The bench holds `msg_ready` low so that a lower-priority message sits in the output register and the edge pin stays pending. It then raises `msg_ready` and the pin's input together, so the delivery and the new edge meet at one edge of the clock. The outcome is judged by counting the messages from that pin: two must appear, one for the old request and one for the new.

// File: rtl/irc_pkg.sv
// Package: shared field positions and constants of a routing entry.
// Assumes 64-bit entries and 8-bit vectors.
package irc_pkg;
    localparam int ENT_W     = 64;
    localparam int VEC_W     = 8;
    localparam int DLV_LO    = 8;
    localparam int DMODE_BIT = 11;
    localparam int POL_BIT   = 13;
    localparam int RIRR_BIT  = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LO   = 56;
    localparam logic [2:0] DLV_EXT = 3'b111;
endpackage

// File: rtl/irc_pending.sv
// Module: per-pin pending register.
// Edge pins latch an unmasked rising edge and clear on delivery (a new edge wins).
// Level pins copy their input every cycle. Assumes inputs are synchronous.
module irc_pending #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_lvl,
    input  logic [N-1:0] trig_lvl,
    input  logic [N-1:0] masked,
    input  logic [N-1:0] served,
    output logic [N-1:0] irr
);
    logic [N-1:0] pin_q;

    // Remember last cycle's input for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_lvl;
    end

    // Update every pending bit according to its trigger type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
        end else begin
            for (int p = 0; p < N; p++) begin
                if (trig_lvl[p])                                irr[p] <= pin_lvl[p];
                else if (pin_lvl[p] && !pin_q[p] && !masked[p]) irr[p] <= 1'b1;
                else if (served[p])                             irr[p] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irc_pick.sv
// Module: fixed-priority picker, lowest index wins.
// Assumes IW is wide enough to hold N-1.
module irc_pick #(
    parameter int N  = 24,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest requesting index is kept.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irc_encode.sv
// Module: builds the message address and data from the fields of one entry.
// Substitutes the externally supplied vector for the external delivery mode.
module irc_encode
    import irc_pkg::*;
#(
    parameter logic [31:0] BASE = 32'hFEE0_0000
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [2:0]       dlv,
    input  logic             dmode,
    input  logic             pol,
    input  logic             trig,
    input  logic [7:0]       dest,
    input  logic [VEC_W-1:0] ext_vec,
    output logic             is_ext,
    output logic [31:0]      addr,
    output logic [31:0]      data
);
    logic [VEC_W-1:0] use_vec;

    // Pick the vector source and pack the address and data words.
    always_comb begin
        is_ext  = (dlv == DLV_EXT);
        use_vec = is_ext ? ext_vec : vec;
        addr    = BASE | (32'(dmode) << 2) | (32'(dest) << 12);
        data    = {16'b0, trig, pol, 3'b000, dlv, use_vec};
    end
endmodule

// File: rtl/irc_router.sv
// Module: interrupt redirection controller top.
// Holds the routing table and the remote-IRR flags, folds legacy input 0
// onto pin 2, picks the lowest eligible pin and registers one message per
// cycle on a valid/ready output. Assumes NUM_PINS >= 3.
module irc_router
    import irc_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [31:0] MSG_BASE = 32'hFEE0_0000,
    localparam int         IW       = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic                cfg_we,
    input  logic [IW-1:0]       cfg_idx,
    input  logic                cfg_hi,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vector,
    input  logic [VEC_W-1:0]    inta_vector,
    output logic                inta_ack,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [31:0]         msg_addr,
    output logic [31:0]         msg_data,
    output logic [IW-1:0]       msg_pin
);
    localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << MASK_BIT;

    logic [ENT_W-1:0]    tbl [NUM_PINS];
    logic [NUM_PINS-1:0] pin_lvl, mask_v, trig_v, rirr_v, irr, elig, served;
    logic                idx_ok, any, ld_en, is_ext;
    logic [IW-1:0]       pick_idx;
    logic [ENT_W-1:0]    sel_ent;
    logic [31:0]         nx_addr, nx_data;

    // Input mapping: pin 0 unsourced, pin 2 shared by inputs 0 and 2.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
        if (p == 0) begin : g_none
            assign pin_lvl[p] = 1'b0;
        end else if (p == 2) begin : g_fold
            assign pin_lvl[p] = irq_in[0] | irq_in[2];
        end else begin : g_direct
            assign pin_lvl[p] = irq_in[p];
        end
    end

    // Gather per-pin mask and trigger bits out of the table.
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            mask_v[p] = tbl[p][MASK_BIT];
            trig_v[p] = tbl[p][TRIG_BIT];
        end
    end

    assign idx_ok = ({1'b0, cfg_idx} < (IW + 1)'(NUM_PINS));

    // Routing table: reset to masked, half-entry writes, bit 14 never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) tbl[p] <= ENT_RST;
        end else if (cfg_we && idx_ok) begin
            if (cfg_hi) tbl[cfg_idx][63:32] <= cfg_wdata;
            else        tbl[cfg_idx][31:0]  <= cfg_wdata & ~(32'(1) << RIRR_BIT);
        end
    end

    // Read port: selected half, remote-IRR merged into the lower half.
    always_comb begin
        cfg_rdata = '0;
        if (idx_ok) begin
            if (cfg_hi) cfg_rdata = tbl[cfg_idx][63:32];
            else        cfg_rdata = tbl[cfg_idx][31:0] | (32'(rirr_v[cfg_idx]) << RIRR_BIT);
        end
    end

    irc_pending #(.N(NUM_PINS)) u_pend (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .trig_lvl(trig_v),
        .masked(mask_v), .served(served), .irr(irr)
    );

    assign elig = irr & ~mask_v & ~(trig_v & rirr_v);

    irc_pick #(.N(NUM_PINS), .IW(IW)) u_pick (
        .req(elig), .any(any), .idx(pick_idx)
    );

    assign ld_en   = any && (!msg_valid || msg_ready);
    assign served  = ld_en ? (NUM_PINS'(1) << pick_idx) : '0;
    assign sel_ent = tbl[pick_idx];

    irc_encode #(.BASE(MSG_BASE)) u_enc (
        .vec(sel_ent[VEC_W-1:0]), .dlv(sel_ent[DLV_LO+2:DLV_LO]),
        .dmode(sel_ent[DMODE_BIT]), .pol(sel_ent[POL_BIT]),
        .trig(sel_ent[TRIG_BIT]), .dest(sel_ent[DEST_LO+7:DEST_LO]),
        .ext_vec(inta_vector), .is_ext(is_ext), .addr(nx_addr), .data(nx_data)
    );

    assign inta_ack = ld_en && is_ext;

    // Remote-IRR: set on delivery of a level pin, cleared by a matching EOI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rirr_v <= '0;
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (ld_en && pick_idx == IW'(p) && trig_v[p])
                    rirr_v[p] <= 1'b1;
                else if (eoi_valid && rirr_v[p] && tbl[p][VEC_W-1:0] == eoi_vector)
                    rirr_v[p] <= 1'b0;
            end
        end
    end

    // Output register: load a new message or drop valid once accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
            msg_pin   <= '0;
        end else if (ld_en) begin
            msg_valid <= 1'b1;
            msg_addr  <= nx_addr;
            msg_data  <= nx_data;
            msg_pin   <= pick_idx;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/irc_router_chk.sv
// Module: protocol and gating checks for irc_router, attached by bind.
module irc_router_chk #(
    parameter int NUM_PINS = 24,
    parameter int IW       = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [31:0]         msg_addr,
    input logic [31:0]         msg_data,
    input logic [IW-1:0]       msg_pin,
    input logic                inta_ack,
    input logic                ld_en,
    input logic [IW-1:0]       pick_idx,
    input logic [NUM_PINS-1:0] mask_v,
    input logic [NUM_PINS-1:0] trig_v,
    input logic [NUM_PINS-1:0] rirr_v
);
    // R1: reset leaves the output idle.
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !msg_valid);

    // R11: a stalled message stays unchanged.
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_pin));

    // R7: a masked entry is never loaded.
    p_masked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !mask_v[pick_idx]);

    // R4: a level pin is loaded only while its remote-IRR is clear.
    p_rirr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && trig_v[pick_idx] |-> !rirr_v[pick_idx]);

    // R4: a level delivery leaves remote-IRR set.
    p_rirr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en && trig_v[pick_idx] |=> rirr_v[msg_pin]);

    // R8: an acknowledge is followed by an external-mode message.
    p_ext_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inta_ack |=> msg_valid && msg_data[10:8] == 3'b111);
endmodule

bind irc_router irc_router_chk #(.NUM_PINS(NUM_PINS), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_pin(msg_pin),
    .inta_ack(inta_ack), .ld_en(ld_en), .pick_idx(pick_idx),
    .mask_v(mask_v), .trig_v(trig_v), .rirr_v(rirr_v)
);

// File: tb/sim_irc_router.sv
`timescale 1ns/100ps
// Bench for irc_router: vector table for message encoding, then directed cases.
module sim_irc_router;
    localparam int NP = 24;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] irq_in = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic          cfg_hi = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic [7:0]    inta_vector = '0;
    logic          inta_ack;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [31:0]   msg_addr, msg_data;
    logic [IW-1:0] msg_pin;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int log_n   = 0;
    int ack_n   = 0;
    int base    = 0;
    int abase   = 0;
    logic [IW-1:0] log_p [256];
    logic [31:0]   log_a [256];
    logic [31:0]   log_d [256];
    int            log_c [256];

    always #2.5 clk = ~clk;

    irc_router u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .inta_vector(inta_vector), .inta_ack(inta_ack), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
        .msg_pin(msg_pin)
    );

    // Cycle counter.
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: record accepted messages and acknowledge pulses at the falling edge.
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready && log_n < 256) begin
            log_p[log_n] = msg_pin;
            log_a[log_n] = msg_addr;
            log_d[log_n] = msg_data;
            log_c[log_n] = cyc;
            log_n = log_n + 1;
        end
        if (rst_n && inta_ack) ack_n = ack_n + 1;
    end

    typedef struct packed {
        logic [4:0]  pin;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [31:0] addr;
        logic [31:0] data;
    } tv_t;

    // R10/R2 encoding vectors: edge-type, unmasked entries.
    localparam tv_t TV [4] = '{
        '{5'd4,  32'h0000_0031, 32'h0100_0000, 32'hFEE0_1000, 32'h0000_0031},
        '{5'd7,  32'h0000_2945, 32'hA500_0000, 32'hFEEA_5004, 32'h0000_4145},
        '{5'd23, 32'h0000_04FE, 32'hFF00_0000, 32'hFEEF_F000, 32'h0000_04FE},
        '{5'd1,  32'h0000_0A10, 32'h0000_0000, 32'hFEE0_0004, 32'h0000_0210}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input bit hi, input logic [31:0] d);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_hi = hi; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int idx, input bit hi, output logic [31:0] v);
        cfg_idx = IW'(idx); cfg_hi = hi;
        #1;
        v = cfg_rdata;
    endtask

    task automatic pulse(input int pin);
        irq_in[pin] = 1'b1;
        tick(1);
        irq_in[pin] = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        tick(1);
        eoi_valid = 1'b0;
    endtask

    task automatic mark();
        base = log_n; abase = ack_n;
    endtask

    // Watchdog: an expired run is a failed check and still prints the summary.
    initial begin
        #500000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(3);
        // R1: reset state.
        chk(msg_valid == 1'b0, "R1 idle valid", 32'(msg_valid), 0);
        chk(inta_ack == 1'b0, "R1 idle ack", 32'(inta_ack), 0);
        rst_n = 1'b1;
        tick(1);
        rd(0, 0, v);  chk(v == 32'h0001_0000, "R1 entry0 lo", v, 32'h0001_0000);
        rd(23, 1, v); chk(v == 32'h0, "R1 entry23 hi", v, 0);
        rd(12, 0, v); chk(v == 32'h0001_0000, "R1 entry12 lo", v, 32'h0001_0000);

        // R10/R2: vector table walk.
        for (int k = 0; k < 4; k++) begin
            wr(TV[k].pin, 1, TV[k].hi);
            wr(TV[k].pin, 0, TV[k].lo);
            mark();
            pulse(TV[k].pin);
            tick(6);
            chk(log_n - base == 1, "R2 one message", 32'(log_n - base), 1);
            chk(log_p[base] == TV[k].pin, "R10 pin", 32'(log_p[base]), 32'(TV[k].pin));
            chk(log_a[base] == TV[k].addr, "R10 addr", log_a[base], TV[k].addr);
            chk(log_d[base] == TV[k].data, "R10 data", log_d[base], TV[k].data);
            wr(TV[k].pin, 0, 32'h0001_0000);
        end

        // R14: out-of-range index.
        wr(24, 0, 32'h0000_1234);
        rd(24, 0, v); chk(v == 32'h0, "R14 read 24", v, 0);
        rd(8, 0, v);  chk(v == 32'h0001_0000, "R14 no alias", v, 32'h0001_0000);

        // R3: masked edge dropped.
        wr(5, 0, 32'h0001_0050);
        mark();
        pulse(5);
        tick(2);
        wr(5, 0, 32'h0000_0050);
        tick(5);
        chk(log_n - base == 0, "R3 masked edge dropped", 32'(log_n - base), 0);
        // R2: same pin now unmasked delivers once.
        mark();
        pulse(5);
        tick(8);
        chk(log_n - base == 1, "R2 single delivery", 32'(log_n - base), 1);
        wr(5, 0, 32'h0001_0050);

        // R4: level pin delivery and remote-IRR gating.
        wr(9, 0, 32'h0000_8061);
        mark();
        irq_in[9] = 1'b1;
        tick(5);
        chk(log_n - base == 1, "R4 level delivered", 32'(log_n - base), 1);
        chk(log_d[base] == 32'h0000_8061, "R4 level data", log_d[base], 32'h0000_8061);
        rd(9, 0, v); chk(v == 32'h0000_C061, "R4 rirr set", v, 32'h0000_C061);
        tick(6);
        chk(log_n - base == 1, "R4 blocked while rirr", 32'(log_n - base), 1);
        // R12: write port cannot clear remote-IRR.
        wr(9, 0, 32'h0000_8061);
        rd(9, 0, v); chk(v == 32'h0000_C061, "R12 rirr kept", v, 32'h0000_C061);
        // R6: non-matching EOI does nothing.
        eoi(8'h62);
        tick(4);
        chk(log_n - base == 1, "R6 other vector", 32'(log_n - base), 1);
        rd(9, 0, v); chk(v == 32'h0000_C061, "R6 rirr stays", v, 32'h0000_C061);
        // R6: matching EOI with input high redelivers.
        eoi(8'h61);
        tick(5);
        chk(log_n - base == 2, "R6 redelivery", 32'(log_n - base), 2);
        rd(9, 0, v); chk(v == 32'h0000_C061, "R6 rirr reset", v, 32'h0000_C061);
        // R5: input dropped, EOI yields nothing.
        irq_in[9] = 1'b0;
        tick(2);
        eoi(8'h61);
        tick(5);
        chk(log_n - base == 2, "R5 no message", 32'(log_n - base), 2);
        rd(9, 0, v); chk(v == 32'h0000_8061, "R5 rirr clear", v, 32'h0000_8061);
        // R12: write cannot set remote-IRR.
        wr(9, 0, 32'h0000_C061);
        rd(9, 0, v); chk(v == 32'h0000_8061, "R12 rirr not set", v, 32'h0000_8061);
        wr(9, 0, 32'h0001_8061);

        // R7: masked level pin silent, unmask delivers.
        wr(10, 0, 32'h0001_8070);
        mark();
        irq_in[10] = 1'b1;
        tick(6);
        chk(log_n - base == 0, "R7 masked silent", 32'(log_n - base), 0);
        wr(10, 0, 32'h0000_8070);
        tick(5);
        chk(log_n - base == 1, "R7 unmask delivers", 32'(log_n - base), 1);
        irq_in[10] = 1'b0;
        wr(10, 0, 32'h0001_8070);
        eoi(8'h70);

        // R8: external vector and acknowledge.
        inta_vector = 8'h9C;
        wr(11, 0, 32'h0000_0712);
        mark();
        pulse(11);
        tick(6);
        chk(log_n - base == 1, "R8 ext delivered", 32'(log_n - base), 1);
        chk(log_d[base] == 32'h0000_079C, "R8 ext vector", log_d[base], 32'h0000_079C);
        chk(ack_n - abase == 1, "R8 one ack", 32'(ack_n - abase), 1);
        wr(11, 0, 32'h0001_0712);

        // R9: legacy input 0 lands on pin 2.
        wr(2, 0, 32'h0000_0022);
        wr(0, 0, 32'h0000_0020);
        mark();
        pulse(0);
        tick(6);
        chk(log_n - base == 1, "R9 one message", 32'(log_n - base), 1);
        chk(log_p[base] == 5'd2, "R9 pin 2", 32'(log_p[base]), 2);
        chk(log_d[base] == 32'h0000_0022, "R9 data", log_d[base], 32'h0000_0022);
        wr(2, 0, 32'h0001_0022);
        wr(0, 0, 32'h0001_0020);

        // R11: ascending order, stall stability, back to back.
        wr(12, 0, 32'h0000_0080);
        wr(13, 0, 32'h0000_0081);
        wr(14, 0, 32'h0000_0082);
        msg_ready = 1'b0;
        mark();
        irq_in[14:12] = 3'b111;
        tick(1);
        irq_in[14:12] = 3'b000;
        tick(3);
        chk(msg_valid && msg_pin == 5'd12, "R11 first held", 32'(msg_pin), 12);
        v = msg_data;
        tick(3);
        chk(msg_pin == 5'd12 && msg_data == v, "R11 stable", msg_data, v);
        msg_ready = 1'b1;
        tick(6);
        chk(log_n - base == 3, "R11 three messages", 32'(log_n - base), 3);
        chk(log_p[base] == 5'd12 && log_p[base+1] == 5'd13 && log_p[base+2] == 5'd14,
            "R11 order", {log_p[base], log_p[base+1], log_p[base+2]}, {5'd12, 5'd13, 5'd14});
        chk(log_c[base+1] - log_c[base] == 1 && log_c[base+2] - log_c[base+1] == 1,
            "R11 back to back", 32'(log_c[base+2] - log_c[base]), 2);

        // R13: new edge in the delivery cycle is kept.
        wr(15, 0, 32'h0000_0090);
        wr(16, 0, 32'h0000_0091);
        msg_ready = 1'b0;
        mark();
        pulse(16);
        tick(3);
        pulse(15);
        tick(3);
        irq_in[15] = 1'b1;
        msg_ready = 1'b1;
        tick(1);
        irq_in[15] = 1'b0;
        tick(6);
        chk(log_n - base == 3, "R13 message count", 32'(log_n - base), 3);
        chk(log_p[base+1] == 5'd15 && log_p[base+2] == 5'd15, "R13 two from pin 15",
            {log_p[base+1], log_p[base+2]}, {5'd15, 5'd15});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule